// File: doc/BRIEF.md
# ADC Conversion Control and Status Unit

This block is the digital control around an eight-channel successive-approximation converter. Software sets a start code, a burst enable, an edge polarity and a channel number in a control register. From these the block decides when to launch a conversion: at once on a software command, or on an edge of one of six external trigger inputs, which may be pins or timer match outputs. The converter itself sits outside the block. The block gives it a one-cycle start pulse and a channel number, and takes back a completion pulse with the result.

Each channel has its own result register that holds the last result, a done flag and an overrun flag. One status word gathers every done and overrun flag so that all channels can be seen in a single read. An interrupt request is raised while any channel that is enabled in a separate mask has its done flag set. A done flag is cleared only by reading the result register of that channel.

Top module: `adc_ctrl`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and `conv_start` is low.
- R2: The status word at address 2 holds the done flags in bits 7:0, the overrun flags in bits 15:8 and the interrupt flag in bit 16. Bits 31:17 always read zero.
- R3: The interrupt flag, and the `irq` output with it, is the OR over channels of done AND the enable bit. The enable mask sits in bits 7:0 at address 1.
- R4: The control register is at address 0: start code in bits 2:0, burst in bit 3, falling-edge select in bit 4, channel in bits 10:8. A write of start code 3'b001 with burst clear, made while idle, gives a one-cycle `conv_start` in the next cycle, with `conv_ch` equal to the written channel. Start code 3'b000 never starts a conversion.
- R5: With burst clear and a stored start code c from 3'b010 to 3'b111, an edge on `trig_in[c-2]` starts a conversion on the stored channel. The edge is rising when bit 4 is 0 and falling when it is 1. `conv_start` is high in the cycle after the third rising clock edge that follows the input change. Edges on the other inputs do nothing.
- R6: While burst is set, neither a software start nor a trigger edge starts a conversion.
- R7: The block is busy from a launch until the next `conv_done`. Any start request that arrives while it is busy is ignored.
- R8: A `conv_done` pulse while busy stores `conv_data` into the result register of the busy channel and sets its done flag. A `conv_done` pulse while idle is ignored. Result register k is at address 8+k: the result in the low bits, overrun in bit 30, done in bit 31.
- R9: A completion on a channel whose done flag is already set also sets that channel's overrun flag, and the new result replaces the old one.
- R10: A read strobe on a channel's result register clears that channel's done and overrun flags. A read of the status word clears nothing.
- R11: When a result read and a completion for the same channel fall in the same cycle, the completion wins: done stays set, and overrun is set if done was already set.
- R12: The control fields and the enable mask read back at their addresses. Any unused address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (reads of result registers have side effects) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| trig_in | input | 6 | Asynchronous trigger sources |
| conv_start | output | 1 | One-cycle launch pulse to the converter |
| conv_ch | output | 3 | Channel of the conversion that is running |
| conv_done | input | 1 | Completion pulse from the converter |
| conv_data | input | RES_W | Conversion result, valid with `conv_done` |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a result read that lands in the same cycle as a completion for the same channel, because the read strobe and the converter's completion come from separate agents. The bench drives the converter directly as a scripted completion pulse, so one directed sequence can place the read strobe and `conv_done` in the same cycle on a channel whose done flag is already set. A long random phase then mixes trigger toggles, control writes and reads against a behavioural model, which catches further overlaps of busy, burst and edge select.

// File: rtl/adc_ctrl.sv
module adc_ctrl #(
  parameter int RES_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [5:0]        trig_in,
  output logic              conv_start,
  output logic [2:0]        conv_ch,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  output logic              irq
);
  localparam int NCH  = 8;
  localparam int NSRC = 6;
  localparam int CH_W = $clog2(NCH);

  logic [2:0]       start_q;
  logic             burst_q, fall_q, busy_q;
  logic [CH_W-1:0]  ch_q, cur_q;
  logic [NCH-1:0]   ien_q, done_q, ovr_q;
  logic [RES_W-1:0] res_q [NCH];
  logic [NSRC-1:0]  sync1_q, sync2_q, prev_q;

  wire wr_ctrl = bus_wr && bus_addr == 4'd0;
  wire wr_ien  = bus_wr && bus_addr == 4'd1;
  wire rd_res  = bus_rd && bus_addr[3];
  wire sw_go   = wr_ctrl && bus_wdata[2:0] == 3'd1 && !bus_wdata[3];

  wire [NSRC-1:0] edges = fall_q ? (prev_q & ~sync2_q) : (sync2_q & ~prev_q);
  logic hw_go;
  always_comb begin
    hw_go = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (!burst_q && start_q == 3'(i + 2)) hw_go = edges[i];
  end

  wire launch = !busy_q && (sw_go || hw_go);
  wire accept = conv_done && busy_q;
  wire irq_flag = |(done_q & ien_q);

  assign irq     = irq_flag;
  assign conv_ch = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q    <= '0;
      burst_q    <= 1'b0;
      fall_q     <= 1'b0;
      ch_q       <= '0;
      ien_q      <= '0;
      busy_q     <= 1'b0;
      cur_q      <= '0;
      conv_start <= 1'b0;
      sync1_q    <= '0;
      sync2_q    <= '0;
      prev_q     <= '0;
      done_q     <= '0;
      ovr_q      <= '0;
      for (int k = 0; k < NCH; k++) res_q[k] <= '0;
    end else begin
      sync1_q    <= trig_in;
      sync2_q    <= sync1_q;
      prev_q     <= sync2_q;
      conv_start <= launch;
      if (wr_ctrl) begin
        start_q <= bus_wdata[2:0];
        burst_q <= bus_wdata[3];
        fall_q  <= bus_wdata[4];
        ch_q    <= bus_wdata[8 +: CH_W];
      end
      if (wr_ien) ien_q <= bus_wdata[NCH-1:0];
      if (launch) begin
        busy_q <= 1'b1;
        cur_q  <= sw_go ? bus_wdata[8 +: CH_W] : ch_q;
      end
      if (accept) busy_q <= 1'b0;
      for (int k = 0; k < NCH; k++) begin
        if (accept && cur_q == CH_W'(k)) begin
          done_q[k] <= 1'b1;
          ovr_q[k]  <= ovr_q[k] | done_q[k];
          res_q[k]  <= conv_data;
        end else if (rd_res && bus_addr[CH_W-1:0] == CH_W'(k)) begin
          done_q[k] <= 1'b0;
          ovr_q[k]  <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[3]) begin
      bus_rdata[31]        = done_q[bus_addr[CH_W-1:0]];
      bus_rdata[30]        = ovr_q[bus_addr[CH_W-1:0]];
      bus_rdata[RES_W-1:0] = res_q[bus_addr[CH_W-1:0]];
    end else begin
      case (bus_addr[2:0])
        3'd0: bus_rdata = {21'd0, ch_q, 3'd0, fall_q, burst_q, start_q};
        3'd1: bus_rdata = {24'd0, ien_q};
        3'd2: bus_rdata = {15'd0, irq_flag, ovr_q, done_q};
        default: bus_rdata = '0;
      endcase
    end
  end

  AST_OVR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) (ovr_q & ~done_q) == '0); // R9
  AST_DONE_CLEAR_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(done_q) & ~done_q)) |-> $past(bus_rd && bus_addr[3])); // R10
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(accept) || $past(wr_ien))); // R3
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !$past(busy_q)); // R7
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R4
endmodule

// File: tb/adc_ctrl_tb.sv
module adc_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [5:0]  trig_in = 0;
  logic        conv_start, conv_done = 0, irq;
  logic [2:0]  conv_ch;
  logic [9:0]  conv_data = 0;

  int checks = 0, failures = 0, cycles = 0;

  adc_ctrl #(.RES_W(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_in(trig_in),
    .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done),
    .conv_data(conv_data), .irq(irq));

  always #4 clk = ~clk;

  // behavioural reference
  bit [2:0] m_start, m_ch, m_cur;
  bit       m_burst, m_fall, m_busy, m_cs;
  bit [7:0] m_ien, m_done, m_ovr;
  int       m_res [8];
  bit [5:0] hist [$];
  bit       sw, hw, launch, accept;
  bit [5:0] nw, od;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_start = 0; m_ch = 0; m_cur = 0; m_burst = 0; m_fall = 0; m_busy = 0; m_cs = 0;
      m_ien = 0; m_done = 0; m_ovr = 0;
      foreach (m_res[k]) m_res[k] = 0;
      hist = '{6'd0, 6'd0, 6'd0};
    end else begin
      nw = hist[hist.size()-2];
      od = hist[hist.size()-3];
      sw = bus_wr && bus_addr == 0 && bus_wdata[2:0] == 3'd1 && !bus_wdata[3];
      hw = 0;
      if (!m_burst && m_start >= 2)
        hw = m_fall ? (od[m_start-2] && !nw[m_start-2]) : (nw[m_start-2] && !od[m_start-2]);
      launch = !m_busy && (sw || hw);
      accept = conv_done && m_busy;
      m_cs = launch;
      if (bus_rd && bus_addr[3] && !(accept && m_cur == bus_addr[2:0])) begin
        m_done[bus_addr[2:0]] = 0;
        m_ovr[bus_addr[2:0]] = 0;
      end
      if (accept) begin
        m_busy = 0;
        if (m_done[m_cur]) m_ovr[m_cur] = 1;
        m_done[m_cur] = 1;
        m_res[m_cur] = int'(conv_data);
      end
      if (launch) begin
        m_busy = 1;
        m_cur = sw ? bus_wdata[10:8] : m_ch;
      end
      if (bus_wr && bus_addr == 0) begin
        m_start = bus_wdata[2:0]; m_burst = bus_wdata[3]; m_fall = bus_wdata[4]; m_ch = bus_wdata[10:8];
      end
      if (bus_wr && bus_addr == 1) m_ien = bus_wdata[7:0];
      hist.push_back(trig_in);
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    logic [31:0] r = 0;
    if (a[3]) r = {m_done[a[2:0]], m_ovr[a[2:0]], 20'd0, 10'(m_res[a[2:0]])};
    else if (a == 0) r = {21'd0, m_ch, 3'd0, m_fall, m_burst, m_start};
    else if (a == 1) r = {24'd0, m_ien};
    else if (a == 2) r = {15'd0, |(m_done & m_ien), m_ovr, m_done};
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, one ns before the rising edge
  always @(negedge clk) begin
    #3;
    chk(rst_n ? "R3 irq" : "R1 irq", {31'd0, irq}, {31'd0, |(m_done & m_ien)});
    chk(rst_n ? "R4 R5 R6 R7 start" : "R1 start", {31'd0, conv_start}, {31'd0, m_cs});
    if (m_cs) chk("R4 R5 channel", {29'd0, conv_ch}, {29'd0, m_cur});
    chk(!rst_n ? "R1 rdata" : bus_addr[3] ? "R8 R9 R11 result" :
        bus_addr == 2 ? "R2 R10 status" : "R12 regs", bus_rdata, exp_rd(bus_addr));
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  task automatic step(); @(negedge clk); endtask
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; step(); bus_wr = 0; bus_wdata = 0;
  endtask
  task automatic rd(input logic [3:0] a);
    bus_rd = 1; bus_addr = a; step(); bus_rd = 0;
  endtask
  task automatic fin(input logic [9:0] d);
    conv_done = 1; conv_data = d; step(); conv_done = 0;
  endtask
  task automatic peek(input logic [3:0] a, input logic [31:0] e, input string tag);
    bus_addr = a; #3; chk(tag, bus_rdata, e); step();
  endtask
  task automatic wait_n(input int n); repeat (n) step(); endtask

  initial begin
    wait_n(4);
    rst_n = 1;
    peek(2, 32'h0, "R1 status after reset");
    peek(0, 32'h0, "R1 ctrl after reset");
    // software start, done, irq, read clearing
    wr(1, 32'h0F);
    wr(0, 32'h301); step(); fin(10'h155);
    peek(2, 32'h0001_0008, "R3 done ch3 with irq");
    peek(11, 32'h8000_0155, "R8 result ch3");
    rd(2);
    peek(2, 32'h0001_0008, "R10 status read keeps done");
    rd(11);
    peek(2, 32'h0, "R10 result read clears done");
    // overrun
    wr(0, 32'h501); step(); fin(10'd1);
    wr(0, 32'h501); step(); fin(10'd2);
    peek(2, 32'h0000_2020, "R9 overrun ch5");
    peek(13, 32'hC000_0002, "R9 overwrite ch5");
    rd(13);
    peek(2, 32'h0, "R10 read clears overrun");
    // read and completion in the same cycle
    wr(0, 32'h201); step(); fin(10'd7);
    wr(0, 32'h201); step();
    conv_done = 1; conv_data = 10'd9; bus_rd = 1; bus_addr = 10; step();
    conv_done = 0; bus_rd = 0;
    peek(10, 32'hC000_0009, "R11 completion wins");
    peek(2, 32'h0001_0404, "R11 status");
    rd(10);
    // starts while busy are ignored
    wr(0, 32'h101); wr(0, 32'h601);
    trig_in[0] = 1; wait_n(4); fin(10'd3);
    peek(2, 32'h0001_0002, "R7 second start ignored");
    rd(9);
    // hardware trigger, rising edge on source 2
    wr(0, 32'h404);
    trig_in[3] = 1; wait_n(5);
    peek(2, 32'h0, "R5 other source ignored");
    trig_in[2] = 1; wait_n(5); fin(10'd4);
    peek(2, 32'h0000_0010, "R5 rising edge start");
    rd(12);
    // falling edge on source 5
    wr(0, 32'h17);
    trig_in[5] = 1; wait_n(5);
    trig_in[5] = 0; wait_n(5); fin(10'd5);
    peek(2, 32'h0001_0001, "R5 falling edge start");
    rd(8);
    // burst blocks all starts; completion while idle ignored
    wr(0, 32'h0C);
    trig_in[2] = 0; wait_n(5); trig_in[2] = 1; wait_n(5);
    wr(0, 32'h9); step(); fin(10'd6);
    peek(2, 32'h0, "R6 burst blocks starts");
    peek(8, 32'h0000_0005, "R8 idle completion ignored");
    // code zero never starts
    wr(0, 32'h700); wait_n(2); fin(10'd1);
    peek(2, 32'h0, "R4 code zero no start");
    peek(0, 32'h700, "R12 ctrl readback");
    peek(1, 32'h0F, "R12 enable readback");
    peek(5, 32'h0, "R12 unused address");
    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = $urandom_range(0, 9);
      bus_wr = (op == 0) || (op == 1);
      bus_rd = (op >= 2) && (op <= 4);
      bus_addr = (op == 0) ? 4'd0 : (op == 1) ? 4'd1 : (op == 2) ? 4'd2 : 4'($urandom_range(0, 15));
      bus_wdata = {21'd0, 3'($urandom), 3'd0, 5'($urandom)};
      if ($urandom_range(0, 5) == 0) trig_in = 6'($urandom);
      conv_done = ($urandom_range(0, 4) == 0);
      conv_data = 10'($urandom);
      step();
    end
    bus_wr = 0; bus_rd = 0; conv_done = 0;
    wait_n(3);
    finish_run();
  end
endmodule